// File: doc/BRIEF.md
# Dual-Bitslice Recovered-Data Merger

This block sits behind a pair of oversampling receive bitslices that track the same serial line half a unit interval apart. Every clock, each bitslice hands over a 4-bit group of recovered bits together with its lock flag, its current delay-tap setting and single-cycle pulses that say its tracking loop has run off one end of the delay line. The block keeps a short history of each bitslice's groups. It chooses one bitslice to supply data and keeps the other as a standby. It emits a gap-free, repeat-free stream of bytes qualified by a valid strobe.

Each bitslice has its own window pointer into its history. A pointer step toward older data (underflow) makes up for a line running slower than the local clock: that cycle yields no group. A step toward newer data (overflow) makes up for a faster line: that cycle yields the skipped group as well as the current one. A boundary event on the supplying bitslice also hands the supply role to the standby from the next cycle on. Groups are packed two to a byte in arrival order.

Top module: `cdr_nibble_merge`

## Requirements
- R1: While reset is low and in the first cycle after it, `word_vld_o` is 0 and `word_o` is 0.
- R2: Each bitslice shifts its 4-bit group into a 12-bit history every cycle, with the newest group in bits 3:0. A pointer value k selects history bits k+3:k. Both pointers start at 4 and stay within 0 to 8.
- R3: No valid byte is produced until both lock inputs are high together. In the first cycle that they are, the bitslice with fewer taps becomes the supplier; the master wins a tie, and output begins from the following cycle.
- R4: In steady running, the supplier contributes one group per cycle, taken at its pointer. Two groups form a byte with the earlier one in bits 3:0, so `word_vld_o` is high every other cycle, one cycle after the second group is taken.
- R5: An underflow pulse on the supplier raises its pointer by 4 and contributes no group that cycle, which produces a two-cycle valid gap. From the next cycle on, the other bitslice supplies.
- R6: An overflow pulse on the supplier lowers its pointer by 4 and contributes two groups that cycle: first the group 4 bits above the new pointer, then the group at the new pointer. This gives valid on consecutive cycles. From the next cycle on, the other bitslice supplies.
- R7: An underflow or overflow pulse on the standby bitslice only moves the standby's pointer. The byte stream and the supplier are unchanged.
- R8: A step that would take a pointer below 0 or above 8 leaves that pointer where it is. The supplier then contributes one group as normal, and a supplier event still hands over the supply role.
- R9: If only one lock drops while running, output continues. If both are low while running, the pending group is discarded, no byte is produced, both pointers return to 4 and R3 applies again.
- R10: Underflow and overflow asserted together on one bitslice are ignored for that bitslice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| mst_nib | input | 4 | Master bitslice recovered group, newest bit in bit 0 |
| slv_nib | input | 4 | Slave bitslice recovered group |
| mst_locked | input | 1 | Master tracking loop locked |
| slv_locked | input | 1 | Slave tracking loop locked |
| mst_taps | input | TAP_W (7) | Master delay-line tap count |
| slv_taps | input | TAP_W (7) | Slave delay-line tap count |
| mst_under | input | 1 | Master underflow pulse (pointer toward older data) |
| mst_over | input | 1 | Master overflow pulse (pointer toward newer data) |
| slv_under | input | 1 | Slave underflow pulse |
| slv_over | input | 1 | Slave overflow pulse |
| word_o | output | 8 | Output byte, earlier group in bits 3:0 |
| word_vld_o | output | 1 | Output byte valid |

## Verification
A wrong pointer value or a wrong supplier choice shows on `word_o` at the next valid byte, one or two cycles after the faulty cycle, as groups from the wrong time slot or from the wrong bitslice. The bench drives distinct streams on the two bitslices so that both kinds of error can be seen. A wrong group count from a pointer step shifts the valid cadence at once: a missing gap or a missing back-to-back pair shows in the next cycle. Every later byte is then misaligned by one group. A failed flush leaves a stale group that corrupts the first byte after relock.

// File: rtl/cdr_nibble_merge_pkg.sv
`timescale 1ns/1ps
package cdr_nibble_merge_pkg;

  typedef enum logic {
    SRC_MST = 1'b0,
    SRC_SLV = 1'b1
  } src_e;

  // number of groups the supplier contributes in one cycle
  function automatic logic [1:0] group_take(input logic emit, input logic step_old,
                                            input logic step_new);
    if (!emit)         return 2'd0;
    else if (step_old) return 2'd0;
    else if (step_new) return 2'd2;
    else               return 2'd1;
  endfunction

endpackage

// File: rtl/cdr_nm_slice.sv
`timescale 1ns/1ps
module cdr_nm_slice #(
  parameter int NIB_W     = 4,
  parameter int HIST_NIBS = 3,
  parameter int PTR_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NIB_W-1:0] din,
  input  logic             under,
  input  logic             over,
  input  logic             enable,
  input  logic             reinit,
  output logic [PTR_W-1:0] ptr_q,
  output logic [NIB_W-1:0] grp_sel,
  output logic [NIB_W-1:0] grp_prev,
  output logic             step_old,
  output logic             step_new,
  output logic             evt
);
  localparam int HIST_W   = NIB_W * HIST_NIBS;
  localparam int PTR_MAX  = HIST_W - NIB_W;
  localparam int PTR_INIT = NIB_W;

  logic [HIST_W-1:0] hist_q;
  logic [PTR_W-1:0]  ptr_eff;
  logic              ev_old, ev_new;
  logic [HIST_W-1:0] sh_sel, sh_prev;

  function automatic logic [PTR_W-1:0] ptr_move(input logic [PTR_W-1:0] p,
                                                input logic up, input logic dn);
    if (up)      return p + PTR_W'(NIB_W);
    else if (dn) return p - PTR_W'(NIB_W);
    else         return p;
  endfunction

  always_comb begin
    ev_old   = enable & under & ~over;
    ev_new   = enable & over & ~under;
    evt      = ev_old | ev_new;
    step_old = ev_old & (ptr_q <= PTR_W'(PTR_MAX - NIB_W));
    step_new = ev_new & (ptr_q >= PTR_W'(NIB_W));
    ptr_eff  = ptr_move(ptr_q, step_old, step_new);
    sh_sel   = hist_q >> ptr_eff;
    sh_prev  = hist_q >> (int'(ptr_eff) + NIB_W);
    grp_sel  = sh_sel[NIB_W-1:0];
    grp_prev = sh_prev[NIB_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= '0;
      ptr_q  <= PTR_W'(PTR_INIT);
    end else begin
      hist_q <= {hist_q[HIST_W-NIB_W-1:0], din};
      ptr_q  <= reinit ? PTR_W'(PTR_INIT) : ptr_eff;
    end
  end
endmodule

// File: rtl/cdr_nm_role.sv
`timescale 1ns/1ps
module cdr_nm_role
  import cdr_nibble_merge_pkg::*;
#(
  parameter int TAP_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mst_locked,
  input  logic             slv_locked,
  input  logic [TAP_W-1:0] mst_taps,
  input  logic [TAP_W-1:0] slv_taps,
  input  logic             sup_evt,
  output logic             run_q,
  output src_e             active_q,
  output logic             flush,
  output logic             start
);
  logic both, none;

  always_comb begin
    both  = mst_locked & slv_locked;
    none  = ~mst_locked & ~slv_locked;
    start = ~run_q & both;
    flush = run_q & none;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      active_q <= SRC_MST;
    end else begin
      if (start)      run_q <= 1'b1;
      else if (flush) run_q <= 1'b0;
      if (start)
        active_q <= (slv_taps < mst_taps) ? SRC_SLV : SRC_MST;
      else if (run_q && !flush && sup_evt)
        active_q <= (active_q == SRC_MST) ? SRC_SLV : SRC_MST;
    end
  end
endmodule

// File: rtl/cdr_nm_pack.sv
`timescale 1ns/1ps
module cdr_nm_pack #(
  parameter int NIB_W    = 4,
  parameter int OUT_NIBS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [1:0]         take,
  input  logic [NIB_W-1:0]   grp_a,
  input  logic [NIB_W-1:0]   grp_b,
  output logic [NIB_W*OUT_NIBS-1:0] word_q,
  output logic               vld_q
);
  localparam int OUT_W = NIB_W * OUT_NIBS;
  localparam int BUF_W = 2 * OUT_W;
  localparam int CNT_W = $clog2(2 * OUT_NIBS + 1);

  logic [BUF_W-1:0] buf_q, merged;
  logic [CNT_W-1:0] cnt_q, total;

  function automatic logic [BUF_W-1:0] place(input logic [NIB_W-1:0] g, input int slot);
    return BUF_W'(g) << (slot * NIB_W);
  endfunction

  always_comb begin
    merged = buf_q;
    if (take != 2'd0) merged = merged | place(grp_a, int'(cnt_q));
    if (take == 2'd2) merged = merged | place(grp_b, int'(cnt_q) + 1);
    total = cnt_q + CNT_W'(take);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q  <= '0;
      cnt_q  <= '0;
      word_q <= '0;
      vld_q  <= 1'b0;
    end else if (flush) begin
      buf_q <= '0;
      cnt_q <= '0;
      vld_q <= 1'b0;
    end else if (total >= CNT_W'(OUT_NIBS)) begin
      word_q <= merged[OUT_W-1:0];
      vld_q  <= 1'b1;
      buf_q  <= merged >> OUT_W;
      cnt_q  <= total - CNT_W'(OUT_NIBS);
    end else begin
      vld_q <= 1'b0;
      buf_q <= merged;
      cnt_q <= total;
    end
  end
endmodule

// File: rtl/cdr_nibble_merge.sv
`timescale 1ns/1ps
module cdr_nibble_merge
  import cdr_nibble_merge_pkg::*;
#(
  parameter int NIB_W     = 4,
  parameter int HIST_NIBS = 3,
  parameter int OUT_NIBS  = 2,
  parameter int TAP_W     = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NIB_W-1:0]          mst_nib,
  input  logic [NIB_W-1:0]          slv_nib,
  input  logic                      mst_locked,
  input  logic                      slv_locked,
  input  logic [TAP_W-1:0]          mst_taps,
  input  logic [TAP_W-1:0]          slv_taps,
  input  logic                      mst_under,
  input  logic                      mst_over,
  input  logic                      slv_under,
  input  logic                      slv_over,
  output logic [NIB_W*OUT_NIBS-1:0] word_o,
  output logic                      word_vld_o
);
  localparam int HIST_W  = NIB_W * HIST_NIBS;
  localparam int PTR_MAX = HIST_W - NIB_W;
  localparam int PTR_W   = $clog2(PTR_MAX + 1);

  logic [1:0][NIB_W-1:0] nib_in, sel, prev;
  logic [1:0]            und_in, ovr_in, up, dn, evt;
  logic [1:0][PTR_W-1:0] ptr;

  // named internal events for the checker
  logic             run_w, flush_w, start_w, emit_w;
  src_e             active_w;
  logic             act_evt_w, act_up_w, act_dn_w, mon_evt_w;
  logic [PTR_W-1:0] act_ptr_w, mst_ptr_w, slv_ptr_w;
  logic [1:0]       take_w;
  logic [NIB_W-1:0] grp_a, grp_b;
  int               a_idx, m_idx;

  assign nib_in = {slv_nib, mst_nib};
  assign und_in = {slv_under, mst_under};
  assign ovr_in = {slv_over, mst_over};

  for (genvar gi = 0; gi < 2; gi++) begin : g_slice
    cdr_nm_slice #(.NIB_W(NIB_W), .HIST_NIBS(HIST_NIBS), .PTR_W(PTR_W)) slice_i (
      .clk(clk), .rst_n(rst_n), .din(nib_in[gi]),
      .under(und_in[gi]), .over(ovr_in[gi]),
      .enable(emit_w), .reinit(flush_w | start_w),
      .ptr_q(ptr[gi]), .grp_sel(sel[gi]), .grp_prev(prev[gi]),
      .step_old(up[gi]), .step_new(dn[gi]), .evt(evt[gi])
    );
  end

  cdr_nm_role #(.TAP_W(TAP_W)) role_i (
    .clk(clk), .rst_n(rst_n), .mst_locked(mst_locked), .slv_locked(slv_locked),
    .mst_taps(mst_taps), .slv_taps(slv_taps), .sup_evt(act_evt_w),
    .run_q(run_w), .active_q(active_w), .flush(flush_w), .start(start_w)
  );

  always_comb begin
    emit_w    = run_w & ~flush_w;
    a_idx     = (active_w == SRC_SLV) ? 1 : 0;
    m_idx     = 1 - a_idx;
    act_evt_w = evt[a_idx];
    act_up_w  = up[a_idx];
    act_dn_w  = dn[a_idx];
    mon_evt_w = evt[m_idx];
    act_ptr_w = ptr[a_idx];
    mst_ptr_w = ptr[0];
    slv_ptr_w = ptr[1];
    take_w    = group_take(emit_w, act_up_w, act_dn_w);
    grp_a     = act_dn_w ? prev[a_idx] : sel[a_idx];
    grp_b     = sel[a_idx];
  end

  cdr_nm_pack #(.NIB_W(NIB_W), .OUT_NIBS(OUT_NIBS)) pack_i (
    .clk(clk), .rst_n(rst_n), .flush(flush_w), .take(take_w),
    .grp_a(grp_a), .grp_b(grp_b), .word_q(word_o), .vld_q(word_vld_o)
  );
endmodule

// File: rtl/cdr_nibble_merge_chk.sv
`timescale 1ns/1ps
module cdr_nibble_merge_chk #(
  parameter int PTR_W   = 4,
  parameter int PTR_MAX = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_w,
  input logic             flush_w,
  input logic             active_w,
  input logic             act_evt_w,
  input logic             act_up_w,
  input logic             act_dn_w,
  input logic             mon_evt_w,
  input logic [PTR_W-1:0] act_ptr_w,
  input logic [PTR_W-1:0] mst_ptr_w,
  input logic [PTR_W-1:0] slv_ptr_w,
  input logic             word_vld_o
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run_w |=> !word_vld_o); // R3
  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_ptr_w <= PTR_W'(PTR_MAX)) && (slv_ptr_w <= PTR_W'(PTR_MAX))); // R2
  AST_SRC_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    act_evt_w |=> (active_w != $past(active_w))); // R5
  AST_UNF_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    act_up_w |=> !word_vld_o); // R5
  AST_OVF_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    act_dn_w |=> word_vld_o); // R6
  AST_MON_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_evt_w && !act_evt_w) |=> ($stable(active_w) && act_ptr_w == $past(act_ptr_w))); // R7
  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    flush_w |=> (!word_vld_o && !run_w)); // R9
endmodule

bind cdr_nibble_merge cdr_nibble_merge_chk #(.PTR_W(PTR_W), .PTR_MAX(PTR_MAX)) chk_i (
  .clk(clk), .rst_n(rst_n), .run_w(run_w), .flush_w(flush_w),
  .active_w(active_w), .act_evt_w(act_evt_w), .act_up_w(act_up_w),
  .act_dn_w(act_dn_w), .mon_evt_w(mon_evt_w), .act_ptr_w(act_ptr_w),
  .mst_ptr_w(mst_ptr_w), .slv_ptr_w(slv_ptr_w), .word_vld_o(word_vld_o)
);

// File: tb/cdr_nibble_merge_tb_top.sv
`timescale 1ns/1ps
module cdr_nibble_merge_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n;
  logic [3:0] mst_nib, slv_nib;
  logic       mst_locked, slv_locked;
  logic [6:0] mst_taps, slv_taps;
  logic       mst_under, mst_over, slv_under, slv_over;
  logic [7:0] word_o;
  logic       word_vld_o;

  cdr_nibble_merge dut_i (.*);

  typedef struct {
    bit         v;
    logic [7:0] d;
    string      req;
  } exp_t;

  exp_t       sb_q[$];
  int         n_run = 0, n_fail = 0;
  int         cyc = 0;
  bit         md_run = 0, md_act = 0;   // md_act: 0 master, 1 slave
  int         md_pos[2] = '{1, 1};      // pointer in groups (pointer value / 4)
  logic [3:0] md_h[2][3];               // [slice][age], age 0 newest
  logic [3:0] md_nq[$];

  task automatic step(input bit ml, input bit sl, input int mt, input int st,
                      input bit mu, input bit mo, input bit su, input bit so,
                      input string req);
    logic [3:0] d[2];
    int         ev[2];
    bit         u[2], o[2];
    int         a, b;
    exp_t       e;
    @(negedge clk);
    d[0] = cyc[3:0];
    d[1] = 4'((cyc * 7 + 3) % 16);
    mst_nib = d[0]; slv_nib = d[1];
    mst_locked = ml; slv_locked = sl;
    mst_taps = 7'(mt); slv_taps = 7'(st);
    mst_under = mu; mst_over = mo; slv_under = su; slv_over = so;
    e.v = 0; e.d = '0; e.req = req;
    u[0] = mu; u[1] = su; o[0] = mo; o[1] = so;
    if (!md_run) begin
      if (ml && sl) begin
        md_run = 1; md_act = (st < mt); md_pos = '{1, 1};
      end
    end else if (!ml && !sl) begin
      md_run = 0; md_nq.delete(); md_pos = '{1, 1};
    end else begin
      for (int s = 0; s < 2; s++)
        ev[s] = (u[s] && !o[s]) ? 1 : ((o[s] && !u[s]) ? 2 : 0);
      a = md_act ? 1 : 0;
      b = 1 - a;
      if (ev[a] == 1) begin
        if (md_pos[a] < 2) md_pos[a]++;
        else md_nq.push_back(md_h[a][md_pos[a]]);
      end else if (ev[a] == 2) begin
        if (md_pos[a] > 0) begin
          md_pos[a]--;
          md_nq.push_back(md_h[a][md_pos[a] + 1]);
          md_nq.push_back(md_h[a][md_pos[a]]);
        end else md_nq.push_back(md_h[a][0]);
      end else md_nq.push_back(md_h[a][md_pos[a]]);
      if (ev[b] == 1 && md_pos[b] < 2) md_pos[b]++;
      if (ev[b] == 2 && md_pos[b] > 0) md_pos[b]--;
      if (ev[a] != 0) md_act = !md_act;
      if (md_nq.size() >= 2) begin
        e.v = 1; e.d = {md_nq[1], md_nq[0]};
        void'(md_nq.pop_front()); void'(md_nq.pop_front());
      end
    end
    for (int s = 0; s < 2; s++) begin
      md_h[s][2] = md_h[s][1]; md_h[s][1] = md_h[s][0]; md_h[s][0] = d[s];
    end
    cyc++;
    sb_q.push_back(e);
  endtask

  task automatic run_n(input int n, input bit ml, input bit sl, input int mt,
                       input int st, input string req);
    for (int i = 0; i < n; i++) step(ml, sl, mt, st, 0, 0, 0, 0, req);
  endtask

  // monitor: pops one expected item per cycle, just after the edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        n_run++;
        if (word_vld_o !== e.v || (e.v && word_o !== e.d)) begin
          n_fail++;
          $display("FAIL %s: vld=%0b data=%02h expected vld=%0b data=%02h",
                   e.req, word_vld_o, word_o, e.v, e.d);
        end
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int s = 0; s < 2; s++)
      for (int k = 0; k < 3; k++) md_h[s][k] = '0;
    rst_n = 0; mst_nib = 0; slv_nib = 0; mst_locked = 0; slv_locked = 0;
    mst_taps = 0; slv_taps = 0; mst_under = 0; mst_over = 0;
    slv_under = 0; slv_over = 0;
    repeat (3) @(posedge clk);
    #1;
    n_run++;
    if (word_vld_o !== 1'b0 || word_o !== 8'h00) begin  // R1
      n_fail++;
      $display("FAIL R1: vld=%0b data=%02h expected vld=0 data=00", word_vld_o, word_o);
    end
    @(negedge clk);
    rst_n = 1;
    run_n(4, 0, 0, 90, 30, "R1");
    run_n(3, 1, 0, 90, 30, "R3");
    run_n(9, 1, 1, 90, 30, "R3");            // slave picked, steady output
    run_n(6, 1, 1, 90, 30, "R4");
    step(1, 1, 90, 30, 0, 0, 1, 0, "R5");   // supplier (slave) underflow
    run_n(6, 1, 1, 90, 30, "R5");
    step(1, 1, 90, 30, 0, 1, 0, 0, "R6");   // supplier (master) overflow
    run_n(6, 1, 1, 90, 30, "R6");
    step(1, 1, 90, 30, 0, 1, 0, 0, "R8");   // standby master already at 0
    run_n(3, 1, 1, 90, 30, "R8");
    step(1, 1, 90, 30, 1, 0, 0, 0, "R7");   // standby master moves 0 to 4
    run_n(4, 1, 1, 90, 30, "R7");
    step(1, 1, 90, 30, 0, 0, 1, 0, "R8");   // supplier slave already at 8
    run_n(4, 1, 1, 90, 30, "R8");
    step(1, 1, 90, 30, 1, 1, 0, 0, "R10");  // both pulses on supplier master
    run_n(4, 1, 1, 90, 30, "R10");
    step(1, 1, 90, 30, 0, 1, 0, 0, "R6");   // master overflow 4 to 0
    step(1, 1, 90, 30, 0, 0, 1, 0, "R5");   // slave back to master
    run_n(4, 1, 1, 90, 30, "R5");
    run_n(4, 1, 0, 90, 30, "R9");           // one lock lost: continues
    run_n(3, 0, 0, 90, 30, "R9");           // both lost: flush
    run_n(8, 1, 1, 20, 50, "R3");           // master picked
    run_n(2, 0, 0, 20, 50, "R9");
    run_n(8, 1, 1, 33, 33, "R3");           // tie: master
    step(1, 1, 33, 33, 0, 0, 0, 1, "R7");   // standby slave overflow
    run_n(6, 1, 1, 33, 33, "R7");
    repeat (3) @(posedge clk);
    #2;
    n_run++;
    if (sb_q.size() != 0) begin
      n_fail++;
      $display("FAIL R4: %0d results outstanding, expected 0", sb_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule